// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a processor core with a 16-bit data bus out of reset. It watches the active-low system reset line and the active-low halt line. Only when both are held low together, without a break, for a programmable number of clock cycles does it treat the event as a real reset. The default count is 100 ms at 125 MHz. On the release of that qualified hold, it reads four 16-bit words from the bottom of memory through a simple request/acknowledge read port. From these it assembles the initial supervisor stack pointer and the initial program counter.

Once the last word has arrived, both 32-bit values are presented with a valid flag, and a one-cycle start pulse tells the core it may begin. A separate request input makes the block drive its own active-low reset output for a fixed number of cycles, which resets peripherals on the board. All inputs are assumed to be synchronous to `clk`.

Top module: `boot_vector_seq`

## Requirements
- R1: After `rst_n` is released and before any stimulus, `bus_req_o` is 0, `vectors_valid_o` is 0, `core_start_o` is 0 and `periph_rst_n_o` is 1.
- R2: Holding only one of `reset_line_n_i` or `halt_n_i` low, for any length of time, never starts a fetch.
- R3: A fetch needs both lines low on at least HOLD_CYCLES consecutive clock edges. A shorter hold, or a hold broken by even one cycle, clears the count and produces no fetch.
- R4: The fetch starts on release and not during the hold. `bus_req_o` rises on the first clock edge at which a line is seen high after a qualified hold.
- R5: Words are read at byte addresses 0, 2, 4 and 6, in that order, one word per cycle with `bus_ack_i` high. `bus_addr_o` stays stable while a request waits for its acknowledge.
- R6: `ssp_o` equals {word at 0, word at 2} and `pc_o` equals {word at 4, word at 6}, with the high half read first.
- R7: The clock edge that captures the fourth word raises `core_start_o` for exactly one cycle and sets `vectors_valid_o`. `vectors_valid_o` stays set until both lines are next low together.
- R8: Both lines low together during a fetch abort it: on the next edge `bus_req_o` and `vectors_valid_o` are 0.
- R9: A high cycle on `periph_rst_req_i` while `periph_rst_n_o` is 1 drives `periph_rst_n_o` low for exactly PULSE_CYCLES cycles. Requests that arrive while it is low are ignored and do not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| reset_line_n_i | input | 1 | Sampled level of the system reset line, active low |
| halt_n_i | input | 1 | Sampled halt line, active low |
| bus_req_o | output | 1 | Word read request |
| bus_addr_o | output | ADDR_W | Byte address of the requested word |
| bus_data_i | input | 16 | Read data |
| bus_ack_i | input | 1 | Read data valid, active high |
| ssp_o | output | 32 | Initial supervisor stack pointer |
| pc_o | output | 32 | Initial program counter |
| vectors_valid_o | output | 1 | Both values hold a completed fetch |
| core_start_o | output | 1 | One-cycle start pulse to the core |
| periph_rst_req_i | input | 1 | Request to reset peripherals |
| periph_rst_n_o | output | 1 | Reset driven to peripherals, active low |

## Verification
The hardest situations to reach are the boundaries of the qualifying window. These are a hold one cycle short of the limit, a hold exactly at the limit, and a long hold with a one-cycle break in it, which must restart the count. The bench reaches them by lowering both lines for an exact number of edges, with the limit set to 16 cycles. A second hard case is an abort in the middle of a fetch. The bench stalls acknowledges with a programmable latency and lowers both lines once the second word has been taken, and so cuts the sequence between words.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam int WORD_W        = 16;
    localparam int VAL_W         = 2 * WORD_W;
    localparam int NUM_WORDS     = 4;
    localparam int IDX_W         = $clog2(NUM_WORDS);
    localparam int BYTES_PER_WRD = WORD_W / 8;

    typedef enum logic {
        FE_IDLE = 1'b0,
        FE_READ = 1'b1
    } fetch_state_e;

    typedef struct packed {
        fetch_state_e                  state;
        logic [IDX_W-1:0]              idx;
        logic [NUM_WORDS*WORD_W-1:0]   vec;
        logic                          valid;
        logic                          start;
    } fetch_regs_t;
endpackage

// File: rtl/boot_hold_qual.sv
module boot_hold_qual #(
    parameter int HOLD_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n_i,
    input  logic halt_n_i,
    output logic both_low_o,
    output logic go_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d     = qual_q;
        both_low_o = !line_n_i && !halt_n_i;
        go_o       = !both_low_o && (qual_q.cnt == HOLD);
        if (both_low_o) begin
            if (qual_q.cnt != HOLD) qual_d.cnt = qual_q.cnt + 1'b1;
        end else begin
            qual_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end

    // Release fires only after the previous cycle was part of a hold
    assert_go_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(both_low_o));
    // Count restarts from zero once release has been seen
    assert_go_clears_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> (qual_q.cnt == '0) || both_low_o);
endmodule

// File: rtl/boot_fetch_engine.sv
module boot_fetch_engine
    import boot_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              go_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic [WORD_W-1:0] bus_data_i,
    input  logic              bus_ack_i,
    output logic [VAL_W-1:0]  ssp_o,
    output logic [VAL_W-1:0]  pc_o,
    output logic              valid_o,
    output logic              start_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    fetch_regs_t fe_d, fe_q;

    always_comb begin
        fe_d       = fe_q;
        fe_d.start = 1'b0;
        if (abort_i) begin
            fe_d.state = FE_IDLE;
            fe_d.valid = 1'b0;
        end else if (go_i) begin
            fe_d.state = FE_READ;
            fe_d.idx   = '0;
            fe_d.valid = 1'b0;
        end else if (fe_q.state == FE_READ && bus_ack_i) begin
            fe_d.vec = {fe_q.vec[(NUM_WORDS-1)*WORD_W-1:0], bus_data_i};
            fe_d.idx = fe_q.idx + 1'b1;
            if (fe_q.idx == LAST_IDX) begin
                fe_d.state = FE_IDLE;
                fe_d.valid = 1'b1;
                fe_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= '0;
        else        fe_q <= fe_d;
    end

    assign bus_req_o  = (fe_q.state == FE_READ);
    assign bus_addr_o = ADDR_W'(fe_q.idx) * ADDR_W'(BYTES_PER_WRD);
    assign ssp_o      = fe_q.vec[2*VAL_W-1:VAL_W];
    assign pc_o       = fe_q.vec[VAL_W-1:0];
    assign valid_o    = fe_q.valid;
    assign start_o    = fe_q.start;

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !abort_i) |=> (bus_req_o && $stable(bus_addr_o)));
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> valid_o);
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!bus_req_o && !valid_o));
endmodule

// File: rtl/boot_periph_pulse.sv
module boot_periph_pulse #(
    parameter int PULSE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic periph_rst_n_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] PULSE = PW'(PULSE_CYCLES);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (pl_q.left != '0)  pl_d.left = pl_q.left - 1'b1;
        else if (req_i)       pl_d.left = PULSE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    assign periph_rst_n_o = (pl_q.left == '0);

    assert_pulse_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_rst_n_o && req_i) |=> (pl_q.left == $past(pl_q.left) - 1'b1));
    assert_pulse_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst_n_o && req_i) |=> !periph_rst_n_o);
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
    import boot_pkg::*;
#(
    parameter int HOLD_CYCLES  = 12_500_000,
    parameter int PULSE_CYCLES = 64,
    parameter int ADDR_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_line_n_i,
    input  logic              halt_n_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic [15:0]       bus_data_i,
    input  logic              bus_ack_i,
    output logic [31:0]       ssp_o,
    output logic [31:0]       pc_o,
    output logic              vectors_valid_o,
    output logic              core_start_o,
    input  logic              periph_rst_req_i,
    output logic              periph_rst_n_o
);
    logic both_low;
    logic go;

    boot_hold_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n_i   (reset_line_n_i),
        .halt_n_i   (halt_n_i),
        .both_low_o (both_low),
        .go_o       (go)
    );

    boot_fetch_engine #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (both_low),
        .go_i       (go),
        .bus_req_o  (bus_req_o),
        .bus_addr_o (bus_addr_o),
        .bus_data_i (bus_data_i),
        .bus_ack_i  (bus_ack_i),
        .ssp_o      (ssp_o),
        .pc_o       (pc_o),
        .valid_o    (vectors_valid_o),
        .start_o    (core_start_o)
    );

    boot_periph_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (periph_rst_req_i),
        .periph_rst_n_o (periph_rst_n_o)
    );

    // A fetch only begins after a cycle with both lines low at the ports
    assert_both_low_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req_o ##1 bus_req_o) |-> $past(reset_line_n_i || halt_n_i) && $past(!reset_line_n_i && !halt_n_i, 2));
endmodule

// File: tb/sim_boot_vector_seq.sv
`timescale 1ns/1ps
module sim_boot_vector_seq;
    localparam int HOLD  = 16;
    localparam int PULSE = 5;
    localparam int AW    = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_n = 1'b1, halt_n = 1'b1;
    logic [15:0] bdata = '0;
    logic back = 1'b0;
    logic preq = 1'b0;
    logic breq, vvalid, cstart, prst_n;
    logic [AW-1:0] baddr;
    logic [31:0] ssp, pc;

    int checks = 0, fails = 0;
    int lat_cfg = 0;
    logic [15:0] seed = 16'h1234;
    bit done = 0;

    always #4 clk = ~clk;

    boot_vector_seq #(.HOLD_CYCLES(HOLD), .PULSE_CYCLES(PULSE), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reset_line_n_i(line_n), .halt_n_i(halt_n),
        .bus_req_o(breq), .bus_addr_o(baddr), .bus_data_i(bdata), .bus_ack_i(back),
        .ssp_o(ssp), .pc_o(pc), .vectors_valid_o(vvalid), .core_start_o(cstart),
        .periph_rst_req_i(preq), .periph_rst_n_o(prst_n));

    function automatic logic [15:0] memw(input logic [15:0] s, input int a);
        return (s + 16'(a) * 16'h1357) ^ 16'h5A5A;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_hold = 0, m_widx = 0, m_pcnt = 0;
    bit m_reading = 0, m_valid = 0, m_start = 0;
    logic [15:0] m_words[4];
    logic [31:0] m_sp = '0, m_pc = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_widx = 0; m_pcnt = 0;
            m_reading = 0; m_valid = 0; m_start = 0;
        end else begin
            m_start = 0;
            if (!line_n && !halt_n) begin
                if (m_hold < HOLD) m_hold++;
                m_reading = 0; m_valid = 0;
            end else begin
                if (m_hold == HOLD) begin
                    m_reading = 1; m_widx = 0; m_valid = 0;
                end else if (m_reading && back) begin
                    m_words[m_widx] = bdata;
                    m_widx++;
                    if (m_widx == 4) begin
                        m_reading = 0; m_valid = 1; m_start = 1;
                        m_sp = {m_words[0], m_words[1]};
                        m_pc = {m_words[2], m_words[3]};
                    end
                end
                m_hold = 0;
            end
            if (m_pcnt > 0) m_pcnt--;
            else if (preq) m_pcnt = PULSE;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 bus_req", 64'(breq), 64'(m_reading));
            if (m_reading) check("R5 bus_addr", 64'(baddr), 64'(m_widx * 2));
            check("R7 valid", 64'(vvalid), 64'(m_valid));
            check("R7 start", 64'(cstart), 64'(m_start));
            if (m_valid) begin
                check("R6 ssp", 64'(ssp), 64'(m_sp));
                check("R6 pc", 64'(pc), 64'(m_pc));
            end
            check("R9 periph_rst_n", 64'(prst_n), 64'(m_pcnt == 0));
        end
    end

    // Memory responder
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            if (breq && !back) begin
                if (w >= lat_cfg) begin
                    back = 1'b1; bdata = memw(seed, int'(baddr)); w = 0;
                end else w++;
            end else begin
                back = 1'b0; w = 0;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_both(input int n);
        @(negedge clk); line_n = 1'b0; halt_n = 1'b0;
        cyc(n);
        line_n = 1'b1; halt_n = 1'b1;
    endtask

    task automatic wait_valid(input string tag);
        int k = 0;
        while (!vvalid && k < 200) begin @(negedge clk); k++; end
        check(tag, 64'(vvalid), 64'd1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 bus_req", 64'(breq), 0);
        check("R1 valid", 64'(vvalid), 0);
        check("R1 start", 64'(cstart), 0);
        check("R1 periph_rst_n", 64'(prst_n), 1);

        // R2 only one line low
        line_n = 1'b0; cyc(3 * HOLD); line_n = 1'b1; cyc(6);
        check("R2 reset-only no fetch", 64'(breq), 0);
        halt_n = 1'b0; cyc(3 * HOLD); halt_n = 1'b1; cyc(6);
        check("R2 halt-only no fetch", 64'(breq), 0);

        // R3 one short
        hold_both(HOLD - 1); cyc(6);
        check("R3 short hold no fetch", 64'(breq), 0);
        // R3 broken hold
        @(negedge clk); line_n = 1'b0; halt_n = 1'b0; cyc(HOLD - 2);
        halt_n = 1'b1; cyc(1); halt_n = 1'b0; cyc(HOLD - 1);
        line_n = 1'b1; halt_n = 1'b1; cyc(6);
        check("R3 broken hold no fetch", 64'(breq), 0);

        // R4/R6 exact hold, zero latency
        lat_cfg = 0; seed = 16'h1234;
        @(negedge clk); line_n = 1'b0; halt_n = 1'b0; cyc(HOLD);
        check("R4 no request during hold", 64'(breq), 0);
        line_n = 1'b1; halt_n = 1'b1; cyc(1);
        check("R4 request after release", 64'(breq), 1);
        wait_valid("R7 valid after exact hold");
        check("R6 ssp exact", 64'(ssp), 64'({memw(seed, 0), memw(seed, 2)}));
        check("R6 pc exact", 64'(pc), 64'({memw(seed, 4), memw(seed, 6)}));
        cyc(5);
        check("R7 valid holds", 64'(vvalid), 1);

        // Long hold, slow memory, new pattern
        lat_cfg = 3; seed = 16'hBEEF;
        hold_both(3 * HOLD);
        wait_valid("R7 valid slow memory");
        check("R6 ssp slow", 64'(ssp), 64'({memw(seed, 0), memw(seed, 2)}));
        check("R6 pc slow", 64'(pc), 64'({memw(seed, 4), memw(seed, 6)}));

        // R8 abort mid fetch
        lat_cfg = 2; seed = 16'h0F0F;
        hold_both(HOLD);
        while (!(breq && baddr == 4)) @(negedge clk);
        line_n = 1'b0; halt_n = 1'b0; cyc(1);
        check("R8 abort drops request", 64'(breq), 0);
        check("R8 abort clears valid", 64'(vvalid), 0);
        cyc(HOLD); line_n = 1'b1; halt_n = 1'b1;
        wait_valid("R8 refetch after abort");
        check("R6 ssp after abort", 64'(ssp), 64'({memw(seed, 0), memw(seed, 2)}));
        check("R6 pc after abort", 64'(pc), 64'({memw(seed, 4), memw(seed, 6)}));

        // R9 peripheral pulse, re-request ignored
        @(negedge clk); preq = 1'b1; cyc(1); preq = 1'b0;
        check("R9 pulse low", 64'(prst_n), 0);
        cyc(2); preq = 1'b1; cyc(1); preq = 1'b0;
        cyc(PULSE - 4);
        check("R9 still low at end", 64'(prst_n), 0);
        cyc(1);
        check("R9 released after PULSE", 64'(prst_n), 1);
        cyc(5);
        finish_up();
    end
endmodule